// File: doc/BRIEF.md
# Resynchronizable Bit-Clock Generator

This block turns a free-running source clock into a slower bit clock for a serial datapath. A programmable divider sets the bit-clock period to a whole number of source cycles. A configuration bit selects whether the divider counts on the rising or the falling source edge. Alongside the bit clock the block gives a one-cycle clock-enable strobe. Logic that runs directly on the source clock uses this strobe in place of the divided clock.

When frame alignment is switched on, the divider starts out free-running. An external frame-sync input is passed through a synchronizer and converted to active-high according to a polarity bit. Every fresh assertion of that input restarts the divider at count zero, so the bit clock keeps a fixed phase to the frame. The same event starts a regenerated internal frame-sync pulse, which is exactly one bit-clock period wide however short or long the external pulse was. All configuration inputs are static and change only while reset is held.

Top module: `bcg_top`

## Requirements
- R1: While rst_n is low, bit_clk, bit_ce and frame_sync are 0 with no clock edge needed. After release the divider count is 0 and the block runs free, without alignment.
- R2: With P = cfg_div + 1 source cycles, the bit clock repeats every P active source edges. Counting active edges after reset release as n = 1, 2, …, bit_clk after edge n is 1 exactly when (n mod P) ≥ floor(P/2).
- R3: bit_clk is low for floor(P/2) and high for ceil(P/2) active edges per period. Even P gives equal halves; odd P makes the high phase one edge longer.
- R4: bit_ce is 1 for exactly one source cycle per period, the first cycle in which bit_clk is high.
- R5: cfg_fall_edge = 1 makes every output change only on falling source edges. cfg_fall_edge = 0 makes them change only on rising edges.
- R6: cfg_fs_low = 1 treats a low level on fs_pin as the active frame sync. cfg_fs_low = 0 treats a high level as active.
- R7: With cfg_sync_en = 0, fs_pin has no effect. The divider keeps free-running and frame_sync stays 0.
- R8: With cfg_sync_en = 1, let edge k be the first active edge at which fs_pin shows the active level after showing the inactive level at edge k−1. At edge k+2 the divider count becomes 0 and bit_clk is low. Counting then continues as in R2 from that point.
- R9: Every restart raises frame_sync at the same edge. frame_sync stays high for exactly P active edges, or longer if a further restart lands inside the pulse.
- R10: A continuously held active frame sync causes one restart only.
- R11: cfg_div = 0 behaves the same as cfg_div = 1, giving a period of two source cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs_pin | input | 1 | External frame sync, asynchronous |
| cfg_div | input | DIV_W | Divider value; period is cfg_div+1 source cycles |
| cfg_fall_edge | input | 1 | 1: count on falling source edge, 0: rising |
| cfg_sync_en | input | 1 | 1: realign the divider to the frame sync |
| cfg_fs_low | input | 1 | 1: frame sync is active low |
| bit_clk | output | 1 | Generated bit clock |
| bit_ce | output | 1 | One-source-cycle enable at each bit-clock rise |
| frame_sync | output | 1 | Regenerated frame-sync pulse, active high |

## Verification
The hardest case to reach from the ports is a frame-sync assertion that lands at an arbitrary divider phase. The bench must then see the restart exactly two edges later, with the pulse width still correct even when the restart coincides with a wrap. The stimulus lets the divider run free for a chosen number of edges, then raises fs_pin at a known sample point. It holds the input active across several periods and later asserts it again at a different phase. A bench model counts the synchronizer delay in edges and predicts every sample. The same pattern is repeated with the falling edge and the inverted polarity selected.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
package bcg_pkg;

   // Source edge on which the whole block advances.
   typedef enum logic [0:0] {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } src_edge_e;

   // Fewest synchronizer flops accepted for the asynchronous frame sync.
   localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/bcg_fs_cond.sv
`timescale 1ns/1ps
// Frame-sync conditioner: polarity fix, synchronizer chain, edge detector.
module bcg_fs_cond #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_pin,
   input  logic fs_active_low,
   input  logic enable,
   output logic restart
);

   logic              fs_level;
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   // Convert to active-high before the first flop.
   assign fs_level = fs_pin ^ fs_active_low;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= fs_level;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   // Only an inactive-to-active change counts; a held level is one event.
   assign restart = enable & chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/bcg_divider.sv
`timescale 1ns/1ps
// Programmable divider with phase split and enable strobe.
module bcg_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_cfg,
   input  logic             restart,
   output logic             wrap,
   output logic             gclk,
   output logic             ce
);

   localparam int CW = DIV_W + 1;

   logic [CW-1:0]    eff_div;
   logic [CW-1:0]    low_len;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cnt_d;
   logic             gclk_d;
   logic             ce_d;

   // A divider value of zero is raised to one: a period needs two edges.
   assign eff_div = (div_cfg == '0) ? CW'(1) : {1'b0, div_cfg};
   // Low phase is floor(period/2); the high phase takes the remainder.
   assign low_len = (eff_div + CW'(1)) >> 1;
   assign wrap    = ({1'b0, cnt_q} == eff_div);

   always_comb begin
      if (restart)   cnt_d = '0;
      else if (wrap) cnt_d = '0;
      else           cnt_d = cnt_q + DIV_W'(1);
      gclk_d = ({1'b0, cnt_d} >= low_len);
      ce_d   = ({1'b0, cnt_d} == low_len);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         gclk  <= 1'b0;
         ce    <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         gclk  <= gclk_d;
         ce    <= ce_d;
      end
   end

endmodule

// File: rtl/bcg_fs_regen.sv
`timescale 1ns/1ps
// Regenerated frame sync: set on restart, cleared on the next natural wrap.
module bcg_fs_regen (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic wrap,
   output logic fs_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fs_out <= 1'b0;
      else if (restart) fs_out <= 1'b1;
      else if (wrap)    fs_out <= 1'b0;
   end

endmodule

// File: rtl/bcg_top.sv
`timescale 1ns/1ps
module bcg_top #(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             src_clk,
   input  logic             rst_n,
   input  logic             fs_pin,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_fall_edge,
   input  logic             cfg_sync_en,
   input  logic             cfg_fs_low,
   output logic             bit_clk,
   output logic             bit_ce,
   output logic             frame_sync
);
   import bcg_pkg::*;

   initial begin
      if (DIV_W < 1)
         $fatal(1, "bcg_top: DIV_W must be at least 1");
      if (SYNC_STAGES < MIN_SYNC_STAGES)
         $fatal(1, "bcg_top: SYNC_STAGES below minimum");
   end

   src_edge_e edge_sel;
   logic      clk_int;
   logic      restart;
   logic      wrap;

   // Edge select by inversion; the configuration bit is static.
   assign edge_sel = src_edge_e'(cfg_fall_edge);
   assign clk_int  = (edge_sel == EDGE_FALL) ? ~src_clk : src_clk;

   bcg_fs_cond #(.STAGES(SYNC_STAGES)) u_cond (
      .clk           (clk_int),
      .rst_n         (rst_n),
      .fs_pin        (fs_pin),
      .fs_active_low (cfg_fs_low),
      .enable        (cfg_sync_en),
      .restart       (restart)
   );

   bcg_divider #(.DIV_W(DIV_W)) u_div (
      .clk     (clk_int),
      .rst_n   (rst_n),
      .div_cfg (cfg_div),
      .restart (restart),
      .wrap    (wrap),
      .gclk    (bit_clk),
      .ce      (bit_ce)
   );

   bcg_fs_regen u_regen (
      .clk     (clk_int),
      .rst_n   (rst_n),
      .restart (restart),
      .wrap    (wrap),
      .fs_out  (frame_sync)
   );

endmodule

// File: rtl/bcg_checker.sv
`timescale 1ns/1ps
module bcg_checker #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] cfg_div,
   input logic             cfg_sync_en,
   input logic             bit_clk,
   input logic             bit_ce,
   input logic             frame_sync
);

   localparam int CW = DIV_W + 2;

   logic [CW-1:0] period;
   logic [CW-1:0] gap_q;
   logic [CW-1:0] fs_run_q;
   logic          seen_ce_q;

   assign period = (cfg_div == '0) ? CW'(2) : CW'(cfg_div) + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q     <= '0;
         fs_run_q  <= '0;
         seen_ce_q <= 1'b0;
      end else begin
         seen_ce_q <= seen_ce_q | bit_ce;
         if (bit_ce)          gap_q <= '0;
         else if (~&gap_q)    gap_q <= gap_q + CW'(1);
         if (!frame_sync)     fs_run_q <= '0;
         else if (~&fs_run_q) fs_run_q <= fs_run_q + CW'(1);
      end
   end

   // R4: the enable only marks high bit-clock cycles
   a_r4_ce_in_high: assert property (@(posedge clk) disable iff (!rst_n)
      bit_ce |-> bit_clk);

   // R4: every rise of the bit clock carries the enable
   a_r4_rise_has_ce: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bit_clk) |-> bit_ce);

   // R2: free-running enables are one period apart
   a_r2_ce_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_sync_en && bit_ce && seen_ce_q) |-> (gap_q == period - CW'(1)));

   // R7: no regenerated frame sync while alignment is off
   a_r7_no_fs_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_sync_en |-> !frame_sync);

   // R8: a restart leaves the bit clock low
   a_r8_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_sync) |-> !bit_clk);

   // R9: the regenerated pulse is at least one period wide
   a_r9_fs_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_sync) |-> (fs_run_q >= period));

endmodule

bind bcg_top bcg_checker #(.DIV_W(DIV_W)) u_chk (
   .clk         (clk_int),
   .rst_n       (rst_n),
   .cfg_div     (cfg_div),
   .cfg_sync_en (cfg_sync_en),
   .bit_clk     (bit_clk),
   .bit_ce      (bit_ce),
   .frame_sync  (frame_sync)
);

// File: tb/test_bcg_top.sv
`timescale 1ns/1ps
module test_bcg_top;

   typedef struct packed {
      logic [7:0] div;
      logic       fall;
      logic [8:0] per;
      logic [8:0] lo;
   } vec_t;

   // Expected period and low-phase length worked out by hand from R2, R3, R11.
   localparam vec_t VECS [9] = '{
      '{8'd1, 1'b0, 9'd2, 9'd1},
      '{8'd2, 1'b0, 9'd3, 9'd1},
      '{8'd3, 1'b0, 9'd4, 9'd2},
      '{8'd4, 1'b0, 9'd5, 9'd2},
      '{8'd7, 1'b0, 9'd8, 9'd4},
      '{8'd0, 1'b0, 9'd2, 9'd1},
      '{8'd6, 1'b1, 9'd7, 9'd3},
      '{8'd1, 1'b1, 9'd2, 9'd1},
      '{8'd5, 1'b1, 9'd6, 9'd3}
   };

   logic       src_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fs_pin = 1'b0;
   logic [7:0] cfg_div = 8'd1;
   logic       cfg_fall_edge = 1'b0;
   logic       cfg_sync_en = 1'b0;
   logic       cfg_fs_low = 1'b0;
   logic       bit_clk, bit_ce, frame_sync;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // bench model state
   int m_per, m_lo, m_cnt, restart_in, stepn;
   bit m_fs, cur_lvl;
   int e_g, e_c, e_f, e_s;
   logic a_g, x_g, a_c, x_c, a_f, x_f;

   always #10 src_clk = ~src_clk;

   bcg_top i_bcg_top (
      .src_clk       (src_clk),
      .rst_n         (rst_n),
      .fs_pin        (fs_pin),
      .cfg_div       (cfg_div),
      .cfg_fall_edge (cfg_fall_edge),
      .cfg_sync_en   (cfg_sync_en),
      .cfg_fs_low    (cfg_fs_low),
      .bit_clk       (bit_clk),
      .bit_ce        (bit_ce),
      .frame_sync    (frame_sync)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
      end
   endtask

   task automatic chk_run(input string tag, input string what, input int errs,
                          input logic act, input logic exp);
      total++;
      if (errs != 0) begin
         bad++;
         $display("FAIL %s %s mismatches=%0d first act=%b exp=%b", tag, what, errs, act, exp);
      end
   endtask

   task automatic active_edge();
      if (cfg_fall_edge) @(negedge src_clk);
      else               @(posedge src_clk);
   endtask

   // One active edge: advance the model, then sample a quarter period later.
   task automatic tick();
      logic eg, ece, snap;
      active_edge();
      stepn++;
      if (restart_in == 1) begin
         m_cnt = 0; m_fs = 1'b1;
      end else if (m_cnt == m_per - 1) begin
         m_cnt = 0; m_fs = 1'b0;
      end else begin
         m_cnt++;
      end
      if (restart_in > 0) restart_in--;
      #5;
      eg  = (m_cnt >= m_lo);
      ece = (m_cnt == m_lo);
      if (bit_clk !== eg)     begin if (e_g == 0) begin a_g = bit_clk;    x_g = eg;   end e_g++; end
      if (bit_ce !== ece)     begin if (e_c == 0) begin a_c = bit_ce;     x_c = ece;  end e_c++; end
      if (frame_sync !== m_fs) begin if (e_f == 0) begin a_f = frame_sync; x_f = m_fs; end e_f++; end
      if (cfg_fall_edge) begin
         snap = bit_clk;
         @(posedge src_clk);
         #2;
         if (bit_clk !== snap) e_s++;
      end
   endtask

   task automatic run(input int n, input string tag);
      e_g = 0; e_c = 0; e_f = 0; e_s = 0;
      a_g = 0; x_g = 0; a_c = 0; x_c = 0; a_f = 0; x_f = 0;
      for (int i = 0; i < n; i++) tick();
      chk_run(tag, "bit_clk", e_g, a_g, x_g);
      chk_run(tag, "bit_ce", e_c, a_c, x_c);
      chk_run(tag, "frame_sync", e_f, a_f, x_f);
      if (cfg_fall_edge) chk_run("R5", "bit_clk moved on rising edge", e_s, 1'b1, 1'b0);
   endtask

   // Drive the logical frame-sync level; R8 restart lands three edges later.
   task automatic set_fs(input bit lvl);
      fs_pin = lvl ^ cfg_fs_low;
      if (cfg_sync_en && lvl && !cur_lvl) restart_in = 3;
      cur_lvl = lvl;
   endtask

   task automatic do_reset(input logic [7:0] d, input bit fall, input bit sen, input bit pol,
                           input int per, input int lo);
      rst_n = 1'b0;
      cfg_div = d; cfg_fall_edge = fall; cfg_sync_en = sen; cfg_fs_low = pol;
      fs_pin = pol; cur_lvl = 1'b0;
      repeat (3) @(posedge src_clk);
      active_edge();
      #5;
      rst_n = 1'b1;
      m_per = per; m_lo = lo; m_cnt = 0; m_fs = 1'b0; restart_in = -1; stepn = 0;
      #1;
      chk("R1", "bit_clk after reset", bit_clk, 1'b0);
      chk("R1", "bit_ce after reset", bit_ce, 1'b0);
      chk("R1", "frame_sync after reset", frame_sync, 1'b0);
   endtask

   initial begin
      #(20 * 100000);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // Table walk: free-running periods, duty split, enable, edge select (R2 R3 R4 R5 R11).
      foreach (VECS[i]) begin
         do_reset(VECS[i].div, VECS[i].fall, 1'b0, 1'b0, int'(VECS[i].per), int'(VECS[i].lo));
         run(3 * int'(VECS[i].per) + 2, "R2/R3/R4/R11");
      end

      // R8 R9 R10: alignment to an active-high frame sync at an arbitrary phase.
      do_reset(8'd3, 1'b0, 1'b1, 1'b0, 4, 2);
      run(5, "R1 free run");
      set_fs(1'b1);
      run(12, "R8 R9");
      run(10, "R10 held");
      set_fs(1'b0);
      run(3, "R8");
      set_fs(1'b1);
      run(10, "R9 second frame");
      set_fs(1'b0);
      run(2, "R9");

      // R6: active-low frame sync, falling-edge mode, odd period.
      do_reset(8'd4, 1'b1, 1'b1, 1'b1, 5, 2);
      run(7, "R6 idle high");
      set_fs(1'b1);
      run(12, "R6 R8");
      set_fs(1'b0);
      run(4, "R6");

      // R7: alignment disabled, frame sync toggles without effect.
      do_reset(8'd4, 1'b0, 1'b0, 1'b0, 5, 2);
      run(4, "R7");
      set_fs(1'b1);
      run(12, "R7 ignored");
      set_fs(1'b0);
      run(3, "R7");

      // R1: asynchronous reset in the middle of a high phase.
      do_reset(8'd7, 1'b0, 1'b0, 1'b0, 8, 4);
      run(6, "R2");
      rst_n = 1'b0;
      #1;
      chk("R1", "bit_clk in async reset", bit_clk, 1'b0);
      chk("R1", "bit_ce in async reset", bit_ce, 1'b0);
      chk("R1", "frame_sync in async reset", frame_sync, 1'b0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule